// File: doc/BRIEF.md
# Filtered Scanline Event Counter

This block watches bit 12 of the video memory address and produces one event per rendered line from it. That address bit goes high whenever a fetch reaches the upper pattern table. Depending on which table the background and the sprites use, it can rise only a few times or dozens of times per line. A rising edge counts only when the bit has been low for a minimum number of CPU phase-clock falling edges beforehand. The short low gaps between fetch groups inside a line are therefore rejected. The long low stretch that falls once per line lets exactly one edge through.

Each accepted edge drives a down-counter. The counter reloads from a software-written value when it is at zero or when a reload has been requested. Otherwise it decrements by one. When an accepted edge leaves the counter at zero while interrupts are enabled, a sticky flag goes high. The CPU side has four write registers, chosen by a 2-bit select: reload value, reload request, disable (which also clears the flag), and enable.

The filter starts primed out of reset, so the first rising edge after reset is accepted without any preceding low time.

Top module: `scanline_edge_counter`

## Requirements
- R1: After reset the count is 0, the flag is 0, interrupts are disabled, the reload value is 0 and no reload is pending.
- R2: A rising edge of `vaddr12` counts only if `vaddr12` stayed low through at least LOW_MIN (default 3) cycles with `cpu_phase_fall` high since it was last high. An edge that follows a shorter low time leaves the count unchanged.
- R3: The first rising edge after reset counts without any preceding strobes.
- R4: A counted edge with the count at 0 loads the reload value. The reload value is written with `reg_sel` = 0.
- R5: A write with `reg_sel` = 1 makes the next counted edge load the reload value whatever the count is, and that edge consumes the request.
- R6: A counted edge with a nonzero count and no pending request lowers the count by one.
- R7: A counted edge that leaves the count at 0 while interrupts are enabled sets `irq_flag`. The flag stays set through later edges.
- R8: A write with `reg_sel` = 2 clears `irq_flag` and disables interrupts, so later zero counts raise nothing. A write with `reg_sel` = 3 enables interrupts.
- R9: A reload-request write in the same cycle as a counted edge does not affect that edge. The request stays pending for the following edge.
- R10: A disable write in the same cycle as a counted edge that reaches 0 leaves `irq_flag` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_phase_fall | input | 1 | One-cycle strobe at each CPU phase-clock falling edge |
| vaddr12 | input | 1 | Video address bit 12, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 reload value, 1 reload request, 2 disable, 3 enable |
| reg_wdata | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| irq_flag | output | 1 | Sticky zero-reached flag |

## Verification
Two functions can fall in the same cycle: the counter update from a counted edge and a CPU register write. The bench provokes this by raising `vaddr12` in the very cycle that a reload-request write lands. It checks that the edge still decrements, and that the edge after it reloads. It also lines up a disable write with the edge that takes the count to zero, and checks that the flag stays clear. Enabling interrupts afterwards must then give a normal flag on the next zero.

// File: rtl/scanline_edge_counter.sv
module scanline_edge_counter #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_phase_fall,
  input  logic             vaddr12,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] count,
  output logic             irq_flag
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(LOW_MIN);

  logic             a12_q;
  logic [LW-1:0]    low_cnt;
  logic [CNT_W-1:0] reload_val;
  logic             reload_req;
  logic             irq_en;
  logic             rise, accept;
  logic             wr_val, wr_req, wr_dis, wr_en;
  logic [CNT_W-1:0] next_count;

  assign rise       = vaddr12 & ~a12_q;
  assign accept     = rise && (low_cnt >= LOW_SAT);
  assign wr_val     = reg_we && (reg_sel == 2'd0);
  assign wr_req     = reg_we && (reg_sel == 2'd1);
  assign wr_dis     = reg_we && (reg_sel == 2'd2);
  assign wr_en      = reg_we && (reg_sel == 2'd3);
  assign next_count = (count == '0 || reload_req) ? reload_val : count - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a12_q      <= 1'b0;
      low_cnt    <= LOW_SAT;
      reload_val <= '0;
      reload_req <= 1'b0;
      irq_en     <= 1'b0;
      irq_flag   <= 1'b0;
      count      <= '0;
    end else begin
      a12_q <= vaddr12;
      if (vaddr12)
        low_cnt <= '0;
      else if (cpu_phase_fall && low_cnt != LOW_SAT)
        low_cnt <= low_cnt + 1'b1;

      if (wr_val) reload_val <= reg_wdata;

      if (wr_req)      reload_req <= 1'b1;
      else if (accept) reload_req <= 1'b0;

      if (accept) count <= next_count;

      if (wr_dis) begin
        irq_en   <= 1'b0;
        irq_flag <= 1'b0;
      end else begin
        if (wr_en) irq_en <= 1'b1;
        if (accept && next_count == '0 && irq_en) irq_flag <= 1'b1;
      end
    end
  end

  p_short_low_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && low_cnt < LOW_SAT) |=> $stable(count));
  p_zero_reloads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && count == '0) |=> count == $past(reload_val));
  p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && count != '0 && !reload_req) |=> count == $past(count) - 1'b1);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !wr_dis) |=> irq_flag);
  p_flag_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> count == '0);
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> !irq_flag);
endmodule

// File: tb/scanline_edge_counter_test.sv
module scanline_edge_counter_test;
  logic clk = 0, rst_n = 0, cpu_phase_fall = 0, vaddr12 = 0, reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] count;
  logic irq_flag;
  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [7:0] c; logic i; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  scanline_edge_counter uut (
    .clk(clk), .rst_n(rst_n), .cpu_phase_fall(cpu_phase_fall), .vaddr12(vaddr12),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .count(count), .irq_flag(irq_flag));

  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (count !== e.c || irq_flag !== e.i) begin
        fails++;
        $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                 e.tag, count, irq_flag, e.c, e.i);
      end
    end
  end

  task automatic expect_out(input logic [7:0] c, input logic i, input string tag);
    exp_t e;
    e.c = c; e.i = i; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic edge_after(input int strobes, input bit w = 0,
                            input logic [1:0] s = 0, input logic [7:0] d = 0);
    vaddr12 = 0;
    step();
    for (int k = 0; k < strobes; k++) begin
      cpu_phase_fall = 1; step(); cpu_phase_fall = 0;
    end
    vaddr12 = 1;
    if (w) begin reg_we = 1; reg_sel = s; reg_wdata = d; end
    step();
    reg_we = 0;
    step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    rst_n = 1;
    expect_out(0, 0, "R1 reset state");
    step();
    wr(2'd0, 8'd5);
    wr(2'd3, 8'd0);
    expect_out(0, 0, "R1 count still zero after setup");
    edge_after(0);
    expect_out(5, 0, "R3/R4 first edge accepted, reload from zero");
    edge_after(0);
    expect_out(5, 0, "R2 edge with no low strobes ignored");
    edge_after(2);
    expect_out(5, 0, "R2 edge after two strobes ignored");
    edge_after(3);
    expect_out(4, 0, "R6 decrement after three strobes");
    edge_after(3); edge_after(3); edge_after(3);
    expect_out(1, 0, "R6 decrement to one");
    edge_after(3);
    expect_out(0, 1, "R7 flag at zero with enable");
    edge_after(3);
    expect_out(5, 1, "R7 flag sticky across reload");
    wr(2'd2, 8'd0);
    expect_out(5, 0, "R8 disable clears flag");
    for (int k = 0; k < 5; k++) edge_after(3);
    expect_out(0, 0, "R8 no flag while disabled");
    wr(2'd3, 8'd0);
    wr(2'd0, 8'd9);
    edge_after(3);
    expect_out(9, 0, "R4 reload with new value");
    edge_after(3);
    expect_out(8, 0, "R6 decrement from nine");
    wr(2'd1, 8'd0);
    edge_after(3);
    expect_out(9, 0, "R5 requested reload at nonzero count");
    edge_after(3);
    expect_out(8, 0, "R5 request consumed");
    edge_after(3, 1, 2'd1, 8'd0);
    expect_out(7, 0, "R9 same-cycle request does not affect edge");
    edge_after(3);
    expect_out(9, 0, "R9 request kept for next edge");
    wr(2'd0, 8'd1);
    wr(2'd1, 8'd0);
    edge_after(3);
    expect_out(1, 0, "R5 reload to one");
    edge_after(3, 1, 2'd2, 8'd0);
    expect_out(0, 0, "R10 same-cycle disable keeps flag clear");
    wr(2'd3, 8'd0);
    edge_after(3);
    expect_out(1, 0, "R8 reload after re-enable");
    edge_after(3);
    expect_out(0, 1, "R8 flag after re-enable");
    step(); step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule